// File: doc/BRIEF.md
# Host and Datapath SRAM Port Merger

This block gives a host processor a path into a set of external SRAM banks that a generated datapath drives at the same time. The host presents one address bus, one write-data bus, a status word and a completion flag from the datapath. The block picks a bank from the upper host address bits and turns the host request into four contributions for that bank: write address, write data, read address and write enable.

Each host contribution is forced to zero unless the matching enable is active. It is then resized to the SRAM width and registered once. The registered value is ORed with the datapath's own signal for that bank. No arbiter sits between the two sides. Correct sharing relies on the host staying quiet while the datapath runs, and on the datapath holding its ports at zero while the host works. A bank whose datapath signal does not exist is marked in a mask, and its SRAM port then carries the host path alone.

Read data from each bank reaches the host only after the host read enable has passed through a chain of single-bit registers. The chain is one stage longer than the SRAM read latency, which leaves room for the host's own return cycle. On every other cycle the returned word is zero.

Top module: `sram_host_merge`

## Requirements
- R1: The bank index is the field of log2(NUM_BANKS) bits that ends just below the host address MSB (host_addr[30:29] with the defaults). The MSB takes no part in bank selection, and at most one bank sees a host write enable in any cycle.
- R2: A bank's host write enable is the AND of three terms: its select, host_stat bit 1 and dp_done. This enable appears on sram_we for that bank one cycle later, ORed with that bank's dp_we.
- R3: A bank's host read enable is the AND of host_stat bit 2 and its select. The gated host read address appears on sram_addr_rd one cycle later.
- R4: host_rdata for a bank equals that bank's sram_rdata in the cycle that lies exactly RD_DELAY+1 cycles after a cycle in which its host read enable was high. In every other cycle host_rdata is zero.
- R5: When the host address is wider than SRAM_AW, the host address paths keep the low SRAM_AW-1 bits and drive the top SRAM address bit as 0. A narrower host address is zero-extended.
- R6: When the host data bus is narrower than SRAM_DW (64 against 72 by default), host write data is zero-extended. A wider bus is truncated to its low SRAM_DW bits.
- R7: A host path whose enable is low contributes zero. When the host is idle, every SRAM output equals the corresponding datapath input, one for one.
- R8: For a bank whose bit in DP_PORT_MASK is 0, the datapath inputs of that bank have no effect on its SRAM outputs.
- R9: A synchronous active-high reset clears all host registers and the read chain. During reset and in the first cycle after it, the SRAM outputs equal the datapath inputs and host_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | HOST_AW | Host address; the upper bits select the bank |
| host_wdata | input | HOST_DW | Host write data |
| host_stat | input | STAT_W | Host status; bit 1 is the memory enable, bit 2 is the read request |
| dp_done | input | 1 | Datapath finished; required for host writes |
| dp_addr_wr | input | NUM_BANKS*SRAM_AW | Datapath write address per bank |
| dp_wdata | input | NUM_BANKS*SRAM_DW | Datapath write data per bank |
| dp_addr_rd | input | NUM_BANKS*SRAM_AW | Datapath read address per bank |
| dp_we | input | NUM_BANKS | Datapath write enable per bank |
| sram_rdata | input | NUM_BANKS*SRAM_DW | Read data returned by each SRAM bank |
| sram_addr_wr | output | NUM_BANKS*SRAM_AW | Merged write address per bank |
| sram_wdata | output | NUM_BANKS*SRAM_DW | Merged write data per bank |
| sram_addr_rd | output | NUM_BANKS*SRAM_AW | Merged read address per bank |
| sram_we | output | NUM_BANKS | Merged write enable per bank |
| host_rdata | output | NUM_BANKS*SRAM_DW | Gated read data per bank toward the host |

## Verification
The assertions check the following on every cycle:
- Host write enables stay one-hot or zero.
- A host-caused write enable always follows a cycle with dp_done high.
- An idle host lane passes the datapath value through unchanged.
- The count of reads in flight matches the state of the release chain.

Only the bench scenarios can show the rest:
- The exact release cycle of read data, and the value of that data.
- Address and data resizing.
- The effect of the port mask and of a reset in the middle of a run.

For these, a behavioural model is compared against every output of every bank on each cycle, through targeted writes, reads, disabled requests, datapath-only traffic and random mixes.

// File: rtl/sram_merge_pkg.sv
package sram_merge_pkg;
   localparam int ST_MEM_EN  = 1;
   localparam int ST_RD_REQ  = 2;
   localparam int ST_MIN_W   = 3;
endpackage

// File: rtl/bank_sel_decoder.sv
module bank_sel_decoder #(
   parameter int NUM_BANKS = 4,
   parameter int HOST_AW   = 32
) (
   input  logic [HOST_AW-1:0]   host_addr,
   output logic [NUM_BANKS-1:0] sel
);
   localparam int SEL_W = $clog2(NUM_BANKS);
   localparam int SEL_HI = HOST_AW - 2;

   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("bank_sel_decoder: NUM_BANKS must be at least 2");
   end
   if (SEL_HI + 1 < SEL_W) begin : g_bad_aw
      $error("bank_sel_decoder: host address too narrow for bank field");
   end

   logic [SEL_W-1:0] field;
   logic             unused_addr;

   assign field       = host_addr[SEL_HI -: SEL_W];
   assign unused_addr = ^host_addr;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
      assign sel[b] = (field == SEL_W'(b));
   end
endmodule

// File: rtl/host_lane.sv
module host_lane #(
   parameter int IN_W    = 32,
   parameter int OUT_W   = 20,
   parameter bit IS_ADDR = 1'b1,
   parameter bit HAS_DP  = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [IN_W-1:0]  host_in,
   input  logic [OUT_W-1:0] dp_in,
   output logic [OUT_W-1:0] sram_out
);
   if (IN_W < 1 || OUT_W < 2) begin : g_bad_w
      $error("host_lane: widths out of range");
   end

   logic [OUT_W-1:0] sized;
   logic [OUT_W-1:0] gated;
   logic [OUT_W-1:0] host_q;

   if (IN_W > OUT_W) begin : g_narrow
      if (IS_ADDR) begin : g_addr
         logic unused_hi;
         assign unused_hi = ^host_in[IN_W-1:OUT_W-1];
         assign sized = {1'b0, host_in[OUT_W-2:0]};
      end else begin : g_data
         logic unused_hi;
         assign unused_hi = ^host_in[IN_W-1:OUT_W];
         assign sized = host_in[OUT_W-1:0];
      end
   end else if (IN_W < OUT_W) begin : g_widen
      assign sized = {{(OUT_W-IN_W){1'b0}}, host_in};
   end else begin : g_same
      assign sized = host_in;
   end

   assign gated = en ? sized : '0;

   always_ff @(posedge clk) begin
      if (rst) host_q <= '0;
      else     host_q <= gated;
   end

   if (HAS_DP) begin : g_merge
      assign sram_out = host_q | dp_in;
   end else begin : g_alone
      logic unused_dp;
      assign unused_dp = ^dp_in;
      assign sram_out  = host_q;
   end

   AST_LANE_IDLE: assert property (@(posedge clk) disable iff (rst)
      $past(!en && !rst) |-> (sram_out == (HAS_DP ? dp_in : '0))); // R7
endmodule

// File: rtl/read_release.sv
module read_release #(
   parameter int DW     = 72,
   parameter int STAGES = 9
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ren,
   input  logic [DW-1:0] rdata,
   output logic [DW-1:0] host_out
);
   localparam int CNT_W = $clog2(STAGES + 2);

   if (STAGES < 2) begin : g_bad_stages
      $error("read_release: at least two stages required");
   end

   logic [STAGES-1:0] chain;
   logic              release_q;

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], ren};
   end

   assign release_q = chain[STAGES-1];
   assign host_out  = release_q ? rdata : '0;

   logic [CNT_W-1:0] inflight;
   always_ff @(posedge clk) begin
      if (rst) inflight <= '0;
      else     inflight <= inflight + CNT_W'(ren) - CNT_W'(release_q);
   end

   AST_RD_INFLIGHT: assert property (@(posedge clk) disable iff (rst)
      inflight == CNT_W'($countones(chain))); // R4
   AST_RD_SOURCE: assert property (@(posedge clk) disable iff (rst)
      $rose(release_q) |-> $past(chain[STAGES-2])); // R4
endmodule

// File: rtl/sram_host_merge.sv
module sram_host_merge
   import sram_merge_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int HOST_AW   = 32,
   parameter int HOST_DW   = 64,
   parameter int STAT_W    = 8,
   parameter int SRAM_AW   = 20,
   parameter int SRAM_DW   = 72,
   parameter int RD_DELAY  = 8,
   parameter logic [NUM_BANKS-1:0] DP_PORT_MASK = '1
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [HOST_AW-1:0]           host_addr,
   input  logic [HOST_DW-1:0]           host_wdata,
   input  logic [STAT_W-1:0]            host_stat,
   input  logic                         dp_done,
   input  logic [NUM_BANKS*SRAM_AW-1:0] dp_addr_wr,
   input  logic [NUM_BANKS*SRAM_DW-1:0] dp_wdata,
   input  logic [NUM_BANKS*SRAM_AW-1:0] dp_addr_rd,
   input  logic [NUM_BANKS-1:0]         dp_we,
   input  logic [NUM_BANKS*SRAM_DW-1:0] sram_rdata,
   output logic [NUM_BANKS*SRAM_AW-1:0] sram_addr_wr,
   output logic [NUM_BANKS*SRAM_DW-1:0] sram_wdata,
   output logic [NUM_BANKS*SRAM_AW-1:0] sram_addr_rd,
   output logic [NUM_BANKS-1:0]         sram_we,
   output logic [NUM_BANKS*SRAM_DW-1:0] host_rdata
);
   localparam int STAGES = RD_DELAY + 1;

   if (STAT_W < ST_MIN_W) begin : g_bad_stat
      $error("sram_host_merge: status word too narrow");
   end
   if (RD_DELAY < 1) begin : g_bad_delay
      $error("sram_host_merge: RD_DELAY must be at least 1");
   end

   logic [NUM_BANKS-1:0] sel;
   logic [NUM_BANKS-1:0] host_wen;
   logic [NUM_BANKS-1:0] host_ren;
   logic [NUM_BANKS-1:0] wen_q;
   logic                 mem_en;
   logic                 rd_req;
   logic                 unused_stat;

   assign mem_en      = host_stat[ST_MEM_EN];
   assign rd_req      = host_stat[ST_RD_REQ];
   assign unused_stat = ^host_stat;

   bank_sel_decoder #(
      .NUM_BANKS (NUM_BANKS),
      .HOST_AW   (HOST_AW)
   ) u_dec (
      .host_addr (host_addr),
      .sel       (sel)
   );

   assign host_wen = sel & {NUM_BANKS{mem_en & dp_done}};
   assign host_ren = sel & {NUM_BANKS{rd_req}};

   always_ff @(posedge clk) begin
      if (rst) wen_q <= '0;
      else     wen_q <= host_wen;
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam bit HAS_DP = DP_PORT_MASK[b];

      if (HAS_DP) begin : g_we_merge
         assign sram_we[b] = wen_q[b] | dp_we[b];
      end else begin : g_we_alone
         logic unused_we;
         assign unused_we  = dp_we[b];
         assign sram_we[b] = wen_q[b];
      end

      host_lane #(
         .IN_W (HOST_AW), .OUT_W (SRAM_AW), .IS_ADDR (1'b1), .HAS_DP (HAS_DP)
      ) u_aw (
         .clk      (clk),
         .rst      (rst),
         .en       (host_wen[b]),
         .host_in  (host_addr),
         .dp_in    (dp_addr_wr[b*SRAM_AW +: SRAM_AW]),
         .sram_out (sram_addr_wr[b*SRAM_AW +: SRAM_AW])
      );

      host_lane #(
         .IN_W (HOST_DW), .OUT_W (SRAM_DW), .IS_ADDR (1'b0), .HAS_DP (HAS_DP)
      ) u_dw (
         .clk      (clk),
         .rst      (rst),
         .en       (host_wen[b]),
         .host_in  (host_wdata),
         .dp_in    (dp_wdata[b*SRAM_DW +: SRAM_DW]),
         .sram_out (sram_wdata[b*SRAM_DW +: SRAM_DW])
      );

      host_lane #(
         .IN_W (HOST_AW), .OUT_W (SRAM_AW), .IS_ADDR (1'b1), .HAS_DP (HAS_DP)
      ) u_ar (
         .clk      (clk),
         .rst      (rst),
         .en       (host_ren[b]),
         .host_in  (host_addr),
         .dp_in    (dp_addr_rd[b*SRAM_AW +: SRAM_AW]),
         .sram_out (sram_addr_rd[b*SRAM_AW +: SRAM_AW])
      );

      read_release #(
         .DW     (SRAM_DW),
         .STAGES (STAGES)
      ) u_rd (
         .clk      (clk),
         .rst      (rst),
         .ren      (host_ren[b]),
         .rdata    (sram_rdata[b*SRAM_DW +: SRAM_DW]),
         .host_out (host_rdata[b*SRAM_DW +: SRAM_DW])
      );

      AST_WE_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
         (sram_we[b] && !(HAS_DP && dp_we[b])) |-> $past(dp_done && mem_en)); // R2
   end

   AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(wen_q)); // R1
   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (host_rdata == '0)); // R9
endmodule

// File: tb/sram_host_merge_tb.sv
module sram_host_merge_tb;
   localparam int NB   = 4;
   localparam int HAW  = 32;
   localparam int HDW  = 64;
   localparam int STW  = 8;
   localparam int AW   = 20;
   localparam int DW   = 72;
   localparam int RDD  = 8;
   localparam int STG  = RDD + 1;
   localparam logic [NB-1:0] MASK = 4'b0111;

   logic clk = 1'b0;
   logic rst;
   logic [HAW-1:0]   host_addr;
   logic [HDW-1:0]   host_wdata;
   logic [STW-1:0]   host_stat;
   logic             dp_done;
   logic [NB*AW-1:0] dp_addr_wr, dp_addr_rd, sram_addr_wr, sram_addr_rd;
   logic [NB*DW-1:0] dp_wdata, sram_rdata, sram_wdata, host_rdata;
   logic [NB-1:0]    dp_we, sram_we;

   always #4 clk = ~clk;

   sram_host_merge #(
      .NUM_BANKS (NB), .HOST_AW (HAW), .HOST_DW (HDW), .STAT_W (STW),
      .SRAM_AW (AW), .SRAM_DW (DW), .RD_DELAY (RDD), .DP_PORT_MASK (MASK)
   ) u_dut (
      .clk (clk), .rst (rst), .host_addr (host_addr), .host_wdata (host_wdata),
      .host_stat (host_stat), .dp_done (dp_done), .dp_addr_wr (dp_addr_wr),
      .dp_wdata (dp_wdata), .dp_addr_rd (dp_addr_rd), .dp_we (dp_we),
      .sram_rdata (sram_rdata), .sram_addr_wr (sram_addr_wr),
      .sram_wdata (sram_wdata), .sram_addr_rd (sram_addr_rd),
      .sram_we (sram_we), .host_rdata (host_rdata)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   // behavioural model: registered host contributions and read history
   logic [AW-1:0] m_aw [NB];
   logic [AW-1:0] m_ar [NB];
   logic [DW-1:0] m_dw [NB];
   logic [NB-1:0] m_we;
   int            m_age [NB][$];

   always @(posedge clk) begin
      for (int b = 0; b < NB; b++) begin
         bit sel, wen, ren;
         sel = (host_addr[30:29] == b[1:0]);
         wen = sel && host_stat[1] && dp_done;
         ren = sel && host_stat[2];
         if (rst) begin
            m_we[b] <= 1'b0; m_aw[b] <= '0; m_ar[b] <= '0; m_dw[b] <= '0;
            m_age[b] = {};
         end else begin
            m_we[b] <= wen;
            m_aw[b] <= wen ? {1'b0, host_addr[AW-2:0]} : '0;
            m_ar[b] <= ren ? {1'b0, host_addr[AW-2:0]} : '0;
            m_dw[b] <= wen ? {{(DW-HDW){1'b0}}, host_wdata} : '0;
            foreach (m_age[b][i]) m_age[b][i] = m_age[b][i] + 1;
            while (m_age[b].size() > 0 && m_age[b][0] > STG) void'(m_age[b].pop_front());
            if (ren) m_age[b].push_back(1);
         end
      end
   end

   task automatic chk(input string tag, input int b, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s bank %0d: actual %h expected %h", tag, b, act, exp);
      end
   endtask

   task automatic check_all(input string ctx);
      for (int b = 0; b < NB; b++) begin
         logic [DW-1:0] e_rd;
         bit rel = 1'b0;
         bit dp = MASK[b];
         foreach (m_age[b][i]) if (m_age[b][i] == STG) rel = 1'b1;
         e_rd = rel ? sram_rdata[b*DW +: DW] : '0;
         chk({ctx, "/R2 we"}, b, DW'(sram_we[b]), DW'(m_we[b] | (dp & dp_we[b])));
         chk({ctx, "/R5 addr_wr"}, b, DW'(sram_addr_wr[b*AW +: AW]),
             DW'(m_aw[b] | (dp ? dp_addr_wr[b*AW +: AW] : '0)));
         chk({ctx, "/R3 addr_rd"}, b, DW'(sram_addr_rd[b*AW +: AW]),
             DW'(m_ar[b] | (dp ? dp_addr_rd[b*AW +: AW] : '0)));
         chk({ctx, "/R6 wdata"}, b, sram_wdata[b*DW +: DW],
             m_dw[b] | (dp ? dp_wdata[b*DW +: DW] : '0));
         chk({ctx, "/R4 rdata"}, b, host_rdata[b*DW +: DW], e_rd);
      end
   endtask

   function automatic logic [HAW-1:0] bank_addr(input int b);
      logic [HAW-1:0] a;
      a = $urandom;
      a[30:29] = b[1:0];
      return a;
   endfunction

   // check outputs, then drive the next inputs (host and SRAM return data)
   task automatic step(input string ctx, input logic [HAW-1:0] a, input logic [STW-1:0] st,
                       input logic done, input bit dp_on);
      @(negedge clk);
      check_all(ctx);
      host_addr  = a;
      host_wdata = {$urandom, $urandom};
      host_stat  = st;
      dp_done    = done;
      for (int b = 0; b < NB; b++) begin
         sram_rdata[b*DW +: DW] = {8'(b), $urandom, $urandom};
         dp_addr_wr[b*AW +: AW] = dp_on ? AW'($urandom) : '0;
         dp_addr_rd[b*AW +: AW] = dp_on ? AW'($urandom) : '0;
         dp_wdata[b*DW +: DW]   = dp_on ? {8'($urandom), $urandom, $urandom} : '0;
         dp_we[b]               = dp_on ? 1'($urandom) : 1'b0;
      end
   endtask

   initial begin
      #(200000 * 8);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      rst = 1'b1;
      host_addr = '0; host_wdata = '0; host_stat = '0; dp_done = 1'b0;
      dp_addr_wr = '0; dp_addr_rd = '0; dp_wdata = '0; dp_we = '0; sram_rdata = '0;
      // R9: reset state, including datapath activity during reset
      repeat (2) step("R9", '0, '0, 1'b0, 1'b0);
      repeat (3) step("R9", bank_addr(1), 8'h06, 1'b1, 1'b1);
      rst = 1'b0;
      step("R9", '0, '0, 1'b0, 1'b0);
      // R1/R2: host writes each bank, address MSB both values
      for (int b = 0; b < NB; b++) begin
         logic [HAW-1:0] a;
         a = bank_addr(b);
         a[31] = b[0];
         a[19] = 1'b1;
         step("R1", a, 8'h02, 1'b1, 1'b0);
         step("R1", '0, '0, 1'b0, 1'b0);
      end
      // R2: write blocked by dp_done low, then by memory enable low
      step("R2", bank_addr(2), 8'h02, 1'b0, 1'b0);
      step("R2", bank_addr(2), 8'hFD, 1'b1, 1'b0);
      step("R2", '0, '0, 1'b0, 1'b0);
      // R3/R4: single read per bank, wait past release
      for (int b = 0; b < NB; b++) begin
         step("R3", bank_addr(b), 8'h04, 1'b0, 1'b0);
         repeat (STG + 2) step("R4", '0, '0, 1'b0, 1'b0);
      end
      // R4: back-to-back reads across banks and repeated to one bank
      for (int k = 0; k < 12; k++) step("R4", bank_addr(k % NB), 8'h04, 1'b0, 1'b0);
      repeat (STG + 2) step("R4", '0, '0, 1'b0, 1'b0);
      // R7/R8: datapath-only traffic, host idle
      repeat (40) step("R7", bank_addr($urandom % NB), 8'h00, 1'b1, 1'b1);
      repeat (20) step("R8", '0, 8'h00, 1'b0, 1'b1);
      // R5/R6: random mix of everything
      repeat (400) step("R6", bank_addr($urandom % NB), STW'($urandom), 1'($urandom), 1'($urandom));
      // R9: reset in the middle of outstanding reads
      for (int k = 0; k < 4; k++) step("R9", bank_addr(k), 8'h06, 1'b1, 1'b0);
      rst = 1'b1;
      repeat (2) step("R9", '0, '0, 1'b0, 1'b1);
      rst = 1'b0;
      repeat (STG + 3) step("R9", '0, '0, 1'b0, 1'b0);
      @(negedge clk);
      check_all("R9");
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule